// File: doc/BRIEF.md
# Transmit Start Gate

This block decides the cycle in which a MAC may begin sending the preamble of a queued transmit frame. It watches how many bytes of the frame already sit in the MAC-side transmit FIFO and compares that count against a start point picked by a 2-bit select. Only bytes in that FIFO count toward the start point. Optionally, it also waits until the frame has been completely fetched into the controller. Bytes that are still in the bus-side FIFO or in external buffer memory do not count. For each frame it issues exactly one single-cycle start pulse.

The wait for a complete fetch is controlled by an underflow-guard bit held in a small control register. That bit only takes effect when external buffer memory is present. Writes to the bit are accepted only while the controller is stopped or suspended. A soft reset clears the bit, and so does the hard reset.

Sequencing uses four named states:
- `ST_IDLE`: no frame is queued.
- `ST_WAIT`: a frame is queued and the start condition is being evaluated.
- `ST_FIRE`: the one cycle in which `tx_start` is high.
- `ST_ARMED`: the pulse has been issued and the block waits for the end of the frame.

The transitions are:
- IDLE→WAIT on `frame_valid`.
- WAIT→FIRE when the start condition holds.
- WAIT→IDLE on `frame_done` (abort, which has priority over firing).
- FIRE→ARMED unconditionally.
- ARMED→IDLE on `frame_done`.

Top module: `tx_start_gate`

## Requirements
- R1: After hard reset `tx_start` is 0 and `cfg_noflo` is 0.
- R2: With the guard ineffective, `start_sel` 0, 1 and 2 start the frame once `mac_bytes` is at least 20, 64 and 128 respectively.
- R3: With the guard ineffective, `start_sel` 3 starts the frame only once `mac_bytes` is at least `frame_len`.
- R4: A frame with `frame_len` below the selected threshold starts as soon as `mac_bytes` reaches `frame_len`.
- R5: When `cfg_noflo` is 1 and `sram_present` is 1, the start additionally requires `fetch_done` to be 1.
- R6: When the guard is effective, `start_sel` 3 loses its whole-frame meaning and uses the 128-byte threshold.
- R7: When `sram_present` is 0, `cfg_noflo` has no effect on the start decision.
- R8: A write on `cfg_wr` updates `cfg_noflo` from `cfg_wr_noflo` only in a cycle where `stop` or `spnd` is 1; otherwise it is ignored.
- R9: `soft_rst` clears `cfg_noflo` on the next edge, with priority over a write in the same cycle; `stop` alone leaves the bit unchanged.
- R10: At most one `tx_start` pulse, one cycle wide, is issued per frame. No further pulse follows until `frame_done` returns the block to idle. A `frame_done` in the waiting state abandons the frame without a pulse.
- R11: `tx_start` is high in the cycle after the edge at which the waiting state first sees the start condition. A newly presented frame spends at least one cycle in the waiting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset, asynchronous |
| soft_rst | input | 1 | Synchronous soft reset of the guard bit |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wr_noflo | input | 1 | Value written to the guard bit |
| stop | input | 1 | Controller stopped |
| spnd | input | 1 | Controller suspended |
| start_sel | input | 2 | Start-point select (0:20 B, 1:64 B, 2:128 B, 3:whole frame) |
| sram_present | input | 1 | External buffer memory is present |
| frame_valid | input | 1 | A transmit frame is queued |
| frame_len | input | CNT_W | Length in bytes of the queued frame |
| mac_bytes | input | CNT_W | Bytes of the frame in the MAC transmit FIFO |
| fetch_done | input | 1 | Whole frame has been fetched into the controller |
| frame_done | input | 1 | Current frame finished or abandoned |
| tx_start | output | 1 | Single-cycle preamble start pulse |
| cfg_noflo | output | 1 | Current value of the guard bit |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a gated control write and a soft reset. The bench drives both in one cycle while `stop` is high and expects `cfg_noflo` to read 0 afterwards. The second pair is a start condition that becomes true just as `frame_done` arrives in the waiting state. The bench drives both together and expects no pulse, followed by a clean return to idle. A byte count that rises cycle by cycle across a threshold pins down the exact pulse cycle. Random frames are then compared against a bench function of threshold, length, fetch status and mode.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FIRE  = 2'd2,
        ST_ARMED = 2'd3
    } tsg_state_e;

    localparam logic [1:0] SEL_SMALL = 2'd0;
    localparam logic [1:0] SEL_MID   = 2'd1;
    localparam logic [1:0] SEL_LARGE = 2'd2;
    localparam logic [1:0] SEL_WHOLE = 2'd3;

endpackage

// File: rtl/tsg_ctl.sv
module tsg_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic wr_en,
    input  logic wr_val,
    input  logic stop,
    input  logic spnd,
    output logic noflo_q
);

    logic wr_ok;

    always_comb begin
        wr_ok = wr_en && (stop || spnd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            noflo_q <= 1'b0;
        end else if (soft_rst) begin
            noflo_q <= 1'b0;
        end else if (wr_ok) begin
            noflo_q <= wr_val;
        end
    end

    AST_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !(stop || spnd)) |=> $stable(noflo_q)); // R8

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !noflo_q); // R9

    AST_WR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && wr_en && stop) |=> (noflo_q == $past(wr_val))); // R8

endmodule

// File: rtl/tsg_thresh.sv
module tsg_thresh #(
    parameter int CNT_W = 12,
    parameter int THR0  = 20,
    parameter int THR1  = 64,
    parameter int THR2  = 128
) (
    input  logic [1:0]       sel,
    input  logic             guard_eff,
    input  logic [CNT_W-1:0] frame_len,
    input  logic [CNT_W-1:0] mac_bytes,
    output logic             point_met
);
    import tsg_pkg::*;

    localparam logic [CNT_W-1:0] T_SMALL = CNT_W'(THR0);
    localparam logic [CNT_W-1:0] T_MID   = CNT_W'(THR1);
    localparam logic [CNT_W-1:0] T_LARGE = CNT_W'(THR2);

    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] limit;

    always_comb begin
        unique case (sel)
            SEL_SMALL: thr = T_SMALL;
            SEL_MID:   thr = T_MID;
            SEL_LARGE: thr = T_LARGE;
            SEL_WHOLE: thr = guard_eff ? T_LARGE : frame_len;
        endcase
    end

    always_comb begin
        limit     = (frame_len < thr) ? frame_len : thr;
        point_met = (mac_bytes >= limit);
    end

endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate #(
    parameter int CNT_W = 12,
    parameter int THR0  = 20,
    parameter int THR1  = 64,
    parameter int THR2  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cfg_wr,
    input  logic             cfg_wr_noflo,
    input  logic             stop,
    input  logic             spnd,
    input  logic [1:0]       start_sel,
    input  logic             sram_present,
    input  logic             frame_valid,
    input  logic [CNT_W-1:0] frame_len,
    input  logic [CNT_W-1:0] mac_bytes,
    input  logic             fetch_done,
    input  logic             frame_done,
    output logic             tx_start,
    output logic             cfg_noflo
);
    import tsg_pkg::*;

    tsg_state_e state_q, state_d;
    logic       guard_eff;
    logic       point_met;
    logic       go;

    tsg_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (cfg_wr),
        .wr_val   (cfg_wr_noflo),
        .stop     (stop),
        .spnd     (spnd),
        .noflo_q  (cfg_noflo)
    );

    always_comb begin
        guard_eff = cfg_noflo && sram_present;
    end

    tsg_thresh #(
        .CNT_W (CNT_W),
        .THR0  (THR0),
        .THR1  (THR1),
        .THR2  (THR2)
    ) u_thr (
        .sel       (start_sel),
        .guard_eff (guard_eff),
        .frame_len (frame_len),
        .mac_bytes (mac_bytes),
        .point_met (point_met)
    );

    always_comb begin
        go = point_met && (!guard_eff || fetch_done);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frame_valid) state_d = ST_WAIT;
            ST_WAIT: begin
                if (frame_done)  state_d = ST_IDLE;
                else if (go)     state_d = ST_FIRE;
            end
            ST_FIRE:  state_d = ST_ARMED;
            ST_ARMED: if (frame_done) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        tx_start = (state_q == ST_FIRE);
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start); // R10

    AST_ARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |=> !tx_start); // R10

    AST_GUARD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> ($past(fetch_done) || !($past(cfg_noflo) && $past(sram_present)))); // R5

    AST_MIN_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (($past(mac_bytes) >= $past(frame_len)) ||
                      ($past(mac_bytes) >= CNT_W'(THR0)))); // R2

    AST_NO_DIRECT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !tx_start); // R11

endmodule

// File: tb/tb_tx_start_gate.sv
`timescale 1ns/1ps
module tb_tx_start_gate;

    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soft_rst = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             cfg_wr_noflo = 1'b0;
    logic             stop = 1'b0;
    logic             spnd = 1'b0;
    logic [1:0]       start_sel = 2'd0;
    logic             sram_present = 1'b0;
    logic             frame_valid = 1'b0;
    logic [CNT_W-1:0] frame_len = '0;
    logic [CNT_W-1:0] mac_bytes = '0;
    logic             fetch_done = 1'b0;
    logic             frame_done = 1'b0;
    logic             tx_start;
    logic             cfg_noflo;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tx_start_gate #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
        .cfg_wr_noflo(cfg_wr_noflo), .stop(stop), .spnd(spnd),
        .start_sel(start_sel), .sram_present(sram_present),
        .frame_valid(frame_valid), .frame_len(frame_len), .mac_bytes(mac_bytes),
        .fetch_done(fetch_done), .frame_done(frame_done),
        .tx_start(tx_start), .cfg_noflo(cfg_noflo)
    );

    function automatic bit exp_go(int sel, int len, int bytes, bit fetched,
                                  bit noflo, bit sram);
        bit guard;
        int thr;
        guard = noflo && sram;
        case (sel)
            0: thr = 20;
            1: thr = 64;
            2: thr = 128;
            default: thr = guard ? 128 : len;
        endcase
        if (len < thr) thr = len;
        return (bytes >= thr) && (!guard || fetched);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_cfg(bit val, bit st, bit sp);
        cfg_wr = 1'b1; cfg_wr_noflo = val; stop = st; spnd = sp;
        tick();
        cfg_wr = 1'b0; stop = 1'b0; spnd = 1'b0;
    endtask

    task automatic set_guard(bit val);
        write_cfg(val, 1'b1, 1'b0);
    endtask

    task automatic run_frame(string req, int sel, int len, int bytes, bit fetched, bit sram);
        bit e;
        bit o1, o2, o3;
        e = exp_go(sel, len, bytes, fetched, cfg_noflo, sram);
        start_sel = 2'(sel); frame_len = CNT_W'(len); mac_bytes = CNT_W'(bytes);
        fetch_done = fetched; sram_present = sram; frame_valid = 1'b1;
        tick(); o1 = tx_start;
        tick(); o2 = tx_start;
        tick(); o3 = tx_start;
        chk(o1 == 1'b0 && o3 == 1'b0, {req, " R10 R11 pulse isolated"}, int'(o1) + int'(o3), 0);
        chk(o2 == e, {req, " start decision"}, int'(o2), int'(e));
        frame_valid = 1'b0; frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        tick(); tick();
        // R1: reset state
        chk(tx_start == 1'b0, "R1 tx_start in reset", int'(tx_start), 0);
        chk(cfg_noflo == 1'b0, "R1 cfg_noflo in reset", int'(cfg_noflo), 0);
        rst_n = 1'b1;
        tick();
        chk(tx_start == 1'b0 && cfg_noflo == 1'b0, "R1 after reset release",
            int'(tx_start) + int'(cfg_noflo), 0);

        // R8: write gating
        write_cfg(1'b1, 1'b0, 1'b0);
        chk(cfg_noflo == 1'b0, "R8 write ignored while running", int'(cfg_noflo), 0);
        write_cfg(1'b1, 1'b1, 1'b0);
        chk(cfg_noflo == 1'b1, "R8 write under stop", int'(cfg_noflo), 1);
        write_cfg(1'b0, 1'b0, 1'b1);
        chk(cfg_noflo == 1'b0, "R8 write under suspend", int'(cfg_noflo), 0);

        // R9: soft reset vs write, stop holds
        soft_rst = 1'b1;
        write_cfg(1'b1, 1'b1, 1'b0);
        soft_rst = 1'b0;
        chk(cfg_noflo == 1'b0, "R9 soft reset beats write", int'(cfg_noflo), 0);
        set_guard(1'b1);
        stop = 1'b1; tick(); tick(); stop = 1'b0;
        chk(cfg_noflo == 1'b1, "R9 stop leaves bit", int'(cfg_noflo), 1);
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        chk(cfg_noflo == 1'b0, "R9 soft reset clears", int'(cfg_noflo), 0);

        // R2 thresholds
        run_frame("R2 sel0 19", 0, 100, 19, 1'b0, 1'b1);
        run_frame("R2 sel0 20", 0, 100, 20, 1'b0, 1'b1);
        run_frame("R2 sel1 63", 1, 200, 63, 1'b0, 1'b1);
        run_frame("R2 sel1 64", 1, 200, 64, 1'b0, 1'b1);
        run_frame("R2 sel2 127", 2, 300, 127, 1'b0, 1'b1);
        run_frame("R2 sel2 128", 2, 300, 128, 1'b0, 1'b1);
        // R3 whole frame
        run_frame("R3 whole 199", 3, 200, 199, 1'b0, 1'b1);
        run_frame("R3 whole 200", 3, 200, 200, 1'b0, 1'b1);
        // R4 short frame
        run_frame("R4 short 9", 2, 10, 9, 1'b0, 1'b1);
        run_frame("R4 short 10", 2, 10, 10, 1'b0, 1'b1);
        // R5 guard needs fetch
        set_guard(1'b1);
        run_frame("R5 guard unfetched", 2, 300, 200, 1'b0, 1'b1);
        run_frame("R5 guard fetched", 2, 300, 200, 1'b1, 1'b1);
        // R6 code 3 under guard
        run_frame("R6 sel3 guard 127", 3, 300, 127, 1'b1, 1'b1);
        run_frame("R6 sel3 guard 128", 3, 300, 128, 1'b1, 1'b1);
        // R7 no sram: guard ignored
        run_frame("R7 nosram unfetched", 0, 100, 20, 1'b0, 1'b0);
        run_frame("R7 nosram sel3", 3, 200, 199, 1'b0, 1'b0);
        set_guard(1'b0);

        // R11 rising fill: pulse exactly the cycle after 64 is seen
        start_sel = 2'd1; frame_len = 12'd200; mac_bytes = 12'd0;
        fetch_done = 1'b0; sram_present = 1'b1; frame_valid = 1'b1;
        tick();
        for (int b = 60; b <= 70; b++) begin
            mac_bytes = CNT_W'(b);
            tick();
            chk(tx_start == (b == 64), "R11 R10 rising fill pulse cycle",
                int'(tx_start), int'(b == 64));
        end
        // R10 still armed: no second pulse while frame stays
        tick(); tick();
        chk(tx_start == 1'b0, "R10 no re-fire while armed", int'(tx_start), 0);
        frame_valid = 1'b0; frame_done = 1'b1; tick(); frame_done = 1'b0; tick();

        // R10 abort: condition and frame_done in the same waiting cycle
        start_sel = 2'd0; frame_len = 12'd100; mac_bytes = 12'd0; frame_valid = 1'b1;
        tick();
        mac_bytes = 12'd50; frame_done = 1'b1;
        tick();
        chk(tx_start == 1'b0, "R10 abort beats start", int'(tx_start), 0);
        frame_done = 1'b0; frame_valid = 1'b0;
        tick();
        chk(tx_start == 1'b0, "R10 idle after abort", int'(tx_start), 0);

        // random frames
        for (int i = 0; i < 300; i++) begin
            int sel, len, bytes;
            bit fet, srm;
            if ($urandom_range(0, 7) == 0) set_guard(1'($urandom_range(0, 1)));
            sel = int'($urandom_range(0, 3));
            len = int'($urandom_range(1, 400));
            case ($urandom_range(0, 2))
                0: bytes = int'($urandom_range(0, len));
                1: bytes = (sel == 0) ? 20 : (sel == 1) ? 64 : (sel == 2) ? 128 : len;
                default: bytes = ((sel == 0) ? 19 : (sel == 1) ? 63 : (sel == 2) ? 127 : len - 1);
            endcase
            if (bytes > len) bytes = len;
            if (bytes < 0) bytes = 0;
            fet = 1'($urandom_range(0, 1));
            srm = 1'($urandom_range(0, 1));
            run_frame("R2 R3 R4 R5 R6 R7 random", sel, len, bytes, fet, srm);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule